// File: doc/BRIEF.md
# Four-State Hard-Decision Trellis Decoder

This block recovers the message bits of a rate-1/2 convolutional code with constraint length 3. The code has four trellis states. On every clock where `in_valid` is high, the decoder takes one received pair of hard-decision parity bits. It scores the pair against the expected output of all eight trellis arcs using a Hamming distance. An add-compare-select stage then updates one accumulated metric for each state. The winning predecessor of each state is recorded as one decision bit, which goes into a per-state serial shift register.

Once enough symbols have arrived to fill the survivor registers, the decoder traces back through the stored decisions. The trace starts from the state with the best metric. It then emits one decoded bit for every further valid symbol, one cycle after that symbol is taken. The first decoded bit belongs to the first message bit. Cycles with `in_valid` low leave every piece of state unchanged and produce no output.

The code generators, the metric width, the reset metric of the non-zero states and the traceback depth are all parameters.

Top module: `vit4_dec`

## Requirements
- R1: The encoder state is `{newest input bit, previous input bit}`. A message bit `u` leaving state `p` produces the pair `{^(G_A & {u,p}), ^(G_B & {u,p})}`, with `G_A` = 3'b111 and `G_B` = 3'b101 by default. That pair arrives as `in_sym[1]` = first parity bit and `in_sym[0]` = second parity bit. An error-free received stream decodes to the message exactly.
- R2: The branch metric of each of the eight arcs is the number of differing bits between `in_sym` and the arc's expected pair. It is 0, 1 or 2 and never 3.
- R3: Synchronous reset sets the metric of state 0 to 0 and the other three metrics to `PM_INIT` (6). It clears the survivor registers and the symbol count. `dout_valid` is low after reset.
- R4: A new state `n` has two predecessors, `{n[0],0}` and `{n[0],1}`. The decoder adds each predecessor's metric to its arc metric and keeps the smaller sum. The second predecessor wins only when its sum is strictly less than the first, so a tie selects `{n[0],0}`.
- R5: After every step the decoder subtracts the smallest of the four new sums from all four. Each stored metric then fits in `PM_W` (4) bits and never needs clipping.
- R6: A cycle with `in_valid` low changes no metric, no survivor register and no count, and `dout_valid` is low in the next cycle.
- R7: The first decoded bit appears one cycle after the `TB_DEPTH`-th valid symbol (16 by default) and equals the first message bit. After that, each valid symbol yields the next message bit one cycle later, with `dout_valid` high.
- R8: The traceback starts from the lowest-numbered state among those with the smallest metric. It walks back `TB_DEPTH-1` stored decisions and outputs the newest-input bit of the state it reaches.
- R9: Single-bit errors spaced more than `TB_DEPTH` symbols apart are corrected in the decoded stream.
- R10: The received pairs 11 10 11 00 01 10 followed by pairs of 00 decode to a 1 followed by zeros. This corrects the two bit errors in that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received pair on `in_sym` is taken this cycle |
| in_sym | input | 2 | Received hard-decision parity pair, bit 1 = first generator |
| dout | output | 1 | Decoded message bit |
| dout_valid | output | 1 | `dout` carries a decoded bit this cycle |

## Verification
The checker checks these properties on every cycle:
- no branch metric ever reaches 3;
- a tie between two sums always takes the first predecessor;
- the normalised metrics never need clipping;
- an idle cycle freezes the metrics and suppresses output;
- every decoded bit follows a valid symbol;
- the metrics after reset have their fixed pattern.

Only the bench's scenarios can show that the traceback actually reconstructs the message. These scenarios are the hand-worked sequence with two errors, a long random message with spaced single errors and idle gaps, and the restart of the latency after a reset in mid-stream.

// File: rtl/vit4_pkg.sv
package vit4_pkg;

   localparam int NST  = 4;          // trellis states
   localparam int SW   = 2;          // state index width
   localparam int NARC = 2 * NST;    // arcs, two into each state

   // expected parity pair when bit_in leaves state pred
   function automatic logic [1:0] arc_pair(input logic [2:0] g_a,
                                           input logic [2:0] g_b,
                                           input logic [1:0] pred,
                                           input logic       bit_in);
      logic [2:0] taps;
      taps = {bit_in, pred};
      return {^(g_a & taps), ^(g_b & taps)};
   endfunction

endpackage

// File: rtl/vit4_bmu.sv
module vit4_bmu
   import vit4_pkg::*;
#(
   parameter logic [2:0] G_A = 3'b111,
   parameter logic [2:0] G_B = 3'b101
) (
   input  logic [1:0]        sym,
   output logic [2*NARC-1:0] bm_flat
);

   // arc index = 2*new_state + branch; branch selects predecessor {ns[0], branch}
   for (genvar ns = 0; ns < NST; ns++) begin : g_ns
      for (genvar br = 0; br < 2; br++) begin : g_br
         localparam logic [1:0] PRED = 2'((ns % 2) * 2 + br);
         localparam logic       UBIT = 1'((ns / 2) % 2);
         localparam logic [1:0] EXP  = arc_pair(G_A, G_B, PRED, UBIT);
         logic [1:0] diff;
         assign diff = sym ^ EXP;
         assign bm_flat[2*(2*ns+br) +: 2] = {diff[1] & diff[0], diff[1] ^ diff[0]};
      end
   end

endmodule

// File: rtl/vit4_acs.sv
module vit4_acs
   import vit4_pkg::*;
#(
   parameter int PM_W    = 4,
   parameter int PM_INIT = 6
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [2*NARC-1:0]       bm_flat,
   output logic [NST*PM_W-1:0]     pm_flat,
   output logic [NST-1:0]          dec,
   output logic [NST*(PM_W+1)-1:0] sum_a_flat,
   output logic [NST*(PM_W+1)-1:0] sum_b_flat,
   output logic [NST*(PM_W+1)-1:0] norm_flat
);

   localparam int               SUM_W  = PM_W + 1;
   localparam logic [SUM_W-1:0] PM_MAX = SUM_W'((1 << PM_W) - 1);

   logic [PM_W-1:0]  pm_q [NST];
   logic [SUM_W-1:0] win  [NST];
   logic [SUM_W-1:0] norm [NST];
   logic [SUM_W-1:0] wmin;

   for (genvar ns = 0; ns < NST; ns++) begin : g_state
      localparam int P0 = (ns % 2) * 2;
      localparam int P1 = P0 + 1;
      logic [SUM_W-1:0] sa;
      logic [SUM_W-1:0] sb;
      logic             lt;

      assign sa = SUM_W'(pm_q[P0]) + SUM_W'(bm_flat[2*(2*ns) +: 2]);
      assign sb = SUM_W'(pm_q[P1]) + SUM_W'(bm_flat[2*(2*ns+1) +: 2]);
      // comparator less-than steers the 2:1 select; equal sums keep P0
      assign lt      = (sb < sa);
      assign win[ns] = lt ? sb : sa;
      assign dec[ns] = lt;
      assign norm[ns] = win[ns] - wmin;

      assign sum_a_flat[SUM_W*ns +: SUM_W] = sa;
      assign sum_b_flat[SUM_W*ns +: SUM_W] = sb;
      assign norm_flat [SUM_W*ns +: SUM_W] = norm[ns];
      assign pm_flat   [PM_W*ns  +: PM_W]  = pm_q[ns];
   end

   always_comb begin
      wmin = win[0];
      for (int s = 1; s < NST; s++) begin
         if (win[s] < wmin) wmin = win[s];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NST; s++) begin
            pm_q[s] <= (s == 0) ? '0 : PM_W'(PM_INIT);
         end
      end else if (en) begin
         for (int s = 0; s < NST; s++) begin
            pm_q[s] <= (norm[s] > PM_MAX) ? PM_MAX[PM_W-1:0] : norm[s][PM_W-1:0];
         end
      end
   end

endmodule

// File: rtl/vit4_smu.sv
module vit4_smu
   import vit4_pkg::*;
#(
   parameter int TB_DEPTH = 16,
   parameter int PM_W     = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic [NST-1:0]      dec,
   input  logic [NST*PM_W-1:0] pm_flat,
   output logic                dout,
   output logic                dout_valid
);

   localparam int            HIST = TB_DEPTH - 1;
   localparam int            CW   = $clog2(TB_DEPTH + 1);
   localparam logic [CW-1:0] FULL = CW'(TB_DEPTH);

   logic [HIST-1:0] sr_q [NST];   // bit 0 holds the newest decision
   logic [CW-1:0]   cnt_q;
   logic            step_q;
   logic [SW-1:0]   best;
   logic [PM_W-1:0] best_pm;
   logic [SW-1:0]   walk;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NST; s++) sr_q[s] <= '0;
         cnt_q  <= '0;
         step_q <= 1'b0;
      end else begin
         step_q <= en;
         if (en) begin
            for (int s = 0; s < NST; s++) begin
               sr_q[s] <= {sr_q[s][HIST-2:0], dec[s]};
            end
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // lowest-numbered state holding the smallest metric
   always_comb begin
      best    = '0;
      best_pm = pm_flat[PM_W-1:0];
      for (int s = 1; s < NST; s++) begin
         if (pm_flat[PM_W*s +: PM_W] < best_pm) begin
            best    = SW'(s);
            best_pm = pm_flat[PM_W*s +: PM_W];
         end
      end
   end

   // walk back: predecessor of state st is {st[0], stored decision}
   always_comb begin
      walk = best;
      for (int j = 0; j < HIST; j++) begin
         walk = {walk[0], sr_q[walk][j]};
      end
   end

   assign dout       = walk[1];
   assign dout_valid = step_q && (cnt_q == FULL);

endmodule

// File: rtl/vit4_dec.sv
module vit4_dec
   import vit4_pkg::*;
#(
   parameter logic [2:0] G_A      = 3'b111,
   parameter logic [2:0] G_B      = 3'b101,
   parameter int         PM_W     = 4,
   parameter int         PM_INIT  = 6,
   parameter int         TB_DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       in_valid,
   input  logic [1:0] in_sym,
   output logic       dout,
   output logic       dout_valid
);

   localparam int SUM_W = PM_W + 1;

   if (PM_W < 3) begin : g_chk_pmw
      $error("vit4_dec: PM_W must be at least 3");
   end
   if (PM_INIT < 1 || PM_INIT > (1 << PM_W) - 3) begin : g_chk_init
      $error("vit4_dec: PM_INIT out of range for PM_W");
   end
   if (TB_DEPTH < 3) begin : g_chk_depth
      $error("vit4_dec: TB_DEPTH must be at least 3");
   end

   logic [2*NARC-1:0]       bm_flat;
   logic [NST*PM_W-1:0]     pm_flat;
   logic [NST-1:0]          dec_vec;
   logic [NST*SUM_W-1:0]    sum_a_flat;
   logic [NST*SUM_W-1:0]    sum_b_flat;
   logic [NST*SUM_W-1:0]    norm_flat;

   vit4_bmu #(.G_A(G_A), .G_B(G_B)) u_bmu (
      .sym     (in_sym),
      .bm_flat (bm_flat)
   );

   vit4_acs #(.PM_W(PM_W), .PM_INIT(PM_INIT)) u_acs (
      .clk        (clk),
      .rst        (rst),
      .en         (in_valid),
      .bm_flat    (bm_flat),
      .pm_flat    (pm_flat),
      .dec        (dec_vec),
      .sum_a_flat (sum_a_flat),
      .sum_b_flat (sum_b_flat),
      .norm_flat  (norm_flat)
   );

   vit4_smu #(.TB_DEPTH(TB_DEPTH), .PM_W(PM_W)) u_smu (
      .clk        (clk),
      .rst        (rst),
      .en         (in_valid),
      .dec        (dec_vec),
      .pm_flat    (pm_flat),
      .dout       (dout),
      .dout_valid (dout_valid)
   );

endmodule

// File: rtl/vit4_dec_chk.sv
module vit4_dec_chk
   import vit4_pkg::*;
#(
   parameter int PM_W    = 4,
   parameter int PM_INIT = 6
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic                    dout_valid,
   input logic [NST*PM_W-1:0]     pm_flat,
   input logic [NST*(PM_W+1)-1:0] sum_a_flat,
   input logic [NST*(PM_W+1)-1:0] sum_b_flat,
   input logic [NST*(PM_W+1)-1:0] norm_flat,
   input logic [NST-1:0]          dec,
   input logic [2*NARC-1:0]       bm_flat
);

   localparam int                  SUM_W    = PM_W + 1;
   localparam logic [SUM_W-1:0]    LIMIT    = SUM_W'((1 << PM_W) - 1);
   localparam logic [NST*PM_W-1:0] INIT_VEC = {PM_W'(PM_INIT), PM_W'(PM_INIT),
                                               PM_W'(PM_INIT), PM_W'(0)};

   for (genvar a = 0; a < NARC; a++) begin : g_arc
      p_bm_range_r2: assert property (@(posedge clk) disable iff (rst)
         bm_flat[2*a +: 2] != 2'd3);
   end

   for (genvar s = 0; s < NST; s++) begin : g_st
      p_tie_first_r4: assert property (@(posedge clk) disable iff (rst)
         (sum_a_flat[SUM_W*s +: SUM_W] == sum_b_flat[SUM_W*s +: SUM_W]) |-> !dec[s]);
      p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
         in_valid |-> (norm_flat[SUM_W*s +: SUM_W] <= LIMIT));
   end

   p_reset_metrics_r3: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pm_flat == INIT_VEC));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(pm_flat) && !dout_valid));

   p_out_follows_in_r7: assert property (@(posedge clk) disable iff (rst)
      dout_valid |-> $past(in_valid));

endmodule

bind vit4_dec vit4_dec_chk #(.PM_W(PM_W), .PM_INIT(PM_INIT)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .dout_valid (dout_valid),
   .pm_flat    (pm_flat),
   .sum_a_flat (sum_a_flat),
   .sum_b_flat (sum_b_flat),
   .norm_flat  (norm_flat),
   .dec        (dec_vec),
   .bm_flat    (bm_flat)
);

// File: tb/vit4_dec_tb.sv
`timescale 1ns/1ps
module vit4_dec_tb;

   localparam int TB_DEPTH = 16;
   localparam int NMSG     = 240;
   localparam int ERR_GAP  = 20;

   // {in_sym[1:0], expected dout_valid, expected dout} per applied symbol (R10)
   localparam logic [3:0] DIR_VEC [0:21] = '{
      4'b1100, 4'b1000, 4'b1100, 4'b0000, 4'b0100, 4'b1000,
      4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
      4'b0000, 4'b0000, 4'b0000, 4'b0011, 4'b0010, 4'b0010,
      4'b0010, 4'b0010, 4'b0010, 4'b0010
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [1:0] in_sym = 2'b00;
   logic       dout;
   logic       dout_valid;

   int checks = 0;
   int fails  = 0;
   logic msg [0:NMSG-1];

   always #2.5 clk = ~clk;

   vit4_dec u_dut (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_sym     (in_sym),
      .dout       (dout),
      .dout_valid (dout_valid)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; in_sym = 2'b00;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // apply one symbol at a falling edge; outputs are read one falling edge later
   task automatic send(input logic [1:0] sym);
      in_valid = 1'b1; in_sym = sym;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [1:0] enc_st;
      int         emitted;

      // R3: reset state
      do_reset();
      @(negedge clk);
      check("R3 dout_valid after reset", dout_valid, 0);

      // R10 / R4 / R7: hand-worked two-error sequence, ties at the first step
      for (int i = 0; i < 22; i++) begin
         send(DIR_VEC[i][3:2]);
         check($sformatf("R10 valid step %0d", i + 1), dout_valid, DIR_VEC[i][1]);
         if (DIR_VEC[i][1]) check($sformatf("R10 bit step %0d", i + 1), dout, DIR_VEC[i][0]);
      end

      // R1 / R9 / R6 / R7 / R8: random message, spaced single errors, idle gaps
      do_reset();
      for (int i = 0; i < NMSG; i++) msg[i] = 1'($urandom_range(0, 1));
      enc_st  = 2'b00;
      emitted = 0;
      for (int i = 0; i < NMSG; i++) begin
         logic [1:0] pair;
         logic [2:0] taps;
         if (i % 7 == 3) begin
            @(negedge clk);
            check("R6 no output on idle cycle", dout_valid, 0);
         end
         taps   = {msg[i], enc_st};
         pair   = {^(3'b111 & taps), ^(3'b101 & taps)};
         enc_st = {msg[i], enc_st[1]};
         if (i % ERR_GAP == 7) pair[(i / ERR_GAP) % 2] = ~pair[(i / ERR_GAP) % 2];
         send(pair);
         if (i + 1 >= TB_DEPTH) begin
            check("R7 decoded bit valid", dout_valid, 1);
            check($sformatf("R9 R1 decoded bit %0d", i + 1 - TB_DEPTH), dout, msg[i + 1 - TB_DEPTH]);
            emitted++;
         end else begin
            check("R7 latency not reached", dout_valid, 0);
         end
      end
      check("R7 decoded count", emitted, NMSG - TB_DEPTH + 1);

      // R3 / R7: reset in mid-stream restarts latency and metrics
      send(2'b11);
      send(2'b10);
      do_reset();
      @(negedge clk);
      check("R3 dout_valid after mid-stream reset", dout_valid, 0);
      for (int i = 0; i < TB_DEPTH + 2; i++) begin
         send(2'b00);
         check("R3 R7 restarted latency", dout_valid, (i + 1 >= TB_DEPTH) ? 1 : 0);
         if (i + 1 >= TB_DEPTH) check("R1 all-zero stream", dout, 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule